// File: doc/BRIEF.md
# Three-Region Address Classifier

This block splits a 24-bit physical address space into a low, a middle and a high region. Two 8-bit limit registers, written and read over a small register port, each give the lower edge of a region in 64-Kbyte steps. Limit 0 is the first address of the middle region. Limit 1 is the first address of the high region. A limit that holds 00H stands for the top of the 16-Mbyte space, so the region it opens is empty.

For each address presented with a valid strobe, the block compares address bits 23..16 against both effective limits. One cycle later it presents a 2-bit region code and three one-hot region flags to downstream logic, such as a wait-state generator.

Top module: `addr_region_classifier`

## Requirements
- R1: After reset both limit registers read 00H, and the region outputs are code 00 with all flags clear.
- R2: A write with `cfg_we`=1 loads `cfg_wdata` into limit 0 when `cfg_sel`=0, or into limit 1 when `cfg_sel`=1. The new value is used from the next clock edge. The other register keeps its value.
- R3: `cfg_rdata` returns the full 8 bits of the register chosen by `cfg_sel` one cycle after `cfg_sel` is sampled.
- R4: The effective limit equals the register value, or 256 when the register holds 00H.
- R5: Let the address page be bits 23..16 of the address. A page below effective limit 0 classifies as low. Otherwise, a page below effective limit 1 classifies as middle. Otherwise the page classifies as high.
- R6: Region codes are 00 for low, 01 for middle and 10 for high. The code 11 never appears.
- R7: Flags are `{high,mid,low}` and exactly one is set after a valid classification. The set flag always agrees with the code.
- R8: Code and flags update one cycle after `addr_valid`=1. They hold their values in cycles without `addr_valid`.
- R9: When limit 1 is at or below limit 0, the middle region is empty. Pages at or above limit 0 classify as high, and the low region keeps precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register select (0 = limit 0, 1 = limit 1) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of selected register, one cycle latency |
| addr_valid | input | 1 | Address strobe |
| addr | input | 24 | Bus address |
| region_code | output | 2 | Registered region code |
| region_flags | output | 3 | Registered one-hot flags {high,mid,low} |

## Verification
The hardest situations to reach from the ports are the ones where a limit holds 00H and the comparison must act as if it were 256. The hardest of these is a page of FFH, which must still fall below such a limit. The bench programs 00H into each limit on its own and into both together, then probes page FFH and the pages at each limit and one step below it. Random limits and addresses are then mixed in. These include equal and inverted limit pairs, which exercise the empty-middle ordering.

// File: rtl/addr_region_pkg.sv
// Package: shared widths and region encoding for the address classifier.
package addr_region_pkg;
    localparam int ADDR_W = 24;
    localparam int PAGE_W = 8;
    typedef enum logic [1:0] {
        REG_LOW  = 2'b00,
        REG_MID  = 2'b01,
        REG_HIGH = 2'b10
    } region_e;
endpackage

// File: rtl/region_limit_regs.sv
// Two limit registers with a write port and a registered read port.
// Assumes a single writer and synchronous active-low reset.
module region_limit_regs #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [PAGE_W-1:0] wdata,
    output logic [PAGE_W-1:0] rdata,
    output logic [PAGE_W-1:0] limit0,
    output logic [PAGE_W-1:0] limit1
);
    // Purpose: load the selected limit register on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit0 <= '0;
            limit1 <= '0;
        end else if (we) begin
            if (sel) limit1 <= wdata;
            else     limit0 <= wdata;
        end
    end

    // Purpose: register the read data of the selected limit.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= sel ? limit1 : limit0;
    end

    a_r2_write_holds_other: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !sel) |=> $stable(limit1));
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel) |=> (limit1 == $past(wdata)));
endmodule

// File: rtl/region_compare.sv
// Combinational region decision from an address page and two limits.
// A limit of zero is widened to 2**PAGE_W (top of memory).
module region_compare
    import addr_region_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] limit0,
    input  logic [PAGE_W-1:0] limit1,
    output region_e           region
);
    localparam int EW = PAGE_W + 1;
    logic [EW-1:0] eff0, eff1, pg;

    // Purpose: widen limits and pick the region by ordered comparison.
    always_comb begin
        pg   = {1'b0, page};
        eff0 = (limit0 == '0) ? EW'(1) << PAGE_W : {1'b0, limit0};
        eff1 = (limit1 == '0) ? EW'(1) << PAGE_W : {1'b0, limit1};
        if (pg < eff0)      region = REG_LOW;
        else if (pg < eff1) region = REG_MID;
        else                region = REG_HIGH;
    end
endmodule

// File: rtl/addr_region_classifier.sv
// Top: limit register file plus registered three-region classification.
// Outputs update one cycle after addr_valid and hold otherwise.
module addr_region_classifier
    import addr_region_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int PW = PAGE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [PW-1:0] cfg_wdata,
    output logic [PW-1:0] cfg_rdata,
    input  logic          addr_valid,
    input  logic [AW-1:0] addr,
    output logic [1:0]    region_code,
    output logic [2:0]    region_flags
);
    logic [PW-1:0] lim0, lim1;
    region_e       reg_next;

    region_limit_regs #(.PAGE_W(PW)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .limit0(lim0), .limit1(lim1)
    );

    region_compare #(.PAGE_W(PW)) cmp_i (
        .page(addr[AW-1 -: PW]), .limit0(lim0), .limit1(lim1), .region(reg_next)
    );

    // Purpose: capture code and one-hot flags on each valid address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_code  <= 2'b00;
            region_flags <= 3'b000;
        end else if (addr_valid) begin
            region_code  <= reg_next;
            region_flags <= 3'b001 << reg_next;
        end
    end

    a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        region_code != 2'b11);
    a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(region_flags));
    a_r7_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (region_flags != 3'b000) |-> region_flags[region_code]);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> ($stable(region_code) && $stable(region_flags)));
    a_r9_low_first: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && lim0 != '0 && addr[AW-1 -: PW] < lim0) |=> region_code == 2'b00);
endmodule

// File: tb/addr_region_classifier_tb_top.sv
module addr_region_classifier_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0, cfg_sel = 0;
    logic [7:0]  cfg_wdata = 0;
    logic [7:0]  cfg_rdata;
    logic        addr_valid = 0;
    logic [23:0] addr = 0;
    logic [1:0]  region_code;
    logic [2:0]  region_flags;
    int total = 0, bad = 0;
    logic [7:0] m0 = 0, m1 = 0;

    always #2 clk = ~clk;

    addr_region_classifier dut_i (.*);

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic logic [1:0] exp_code(logic [7:0] a, logic [7:0] l0, logic [7:0] l1);
        int e0 = (l0 == 0) ? 256 : l0;   // R4
        int e1 = (l1 == 0) ? 256 : l1;
        if (a < e0) return 2'b00;        // R5
        if (a < e1) return 2'b01;
        return 2'b10;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic s, logic [7:0] d);
        @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
        if (s) m1 = d; else m0 = d;
    endtask

    task automatic rd_check(logic s, string req);
        @(negedge clk); cfg_sel = s;
        @(negedge clk); check(req, cfg_rdata, s ? m1 : m0);
    endtask

    task automatic classify(logic [23:0] a, string req);
        logic [1:0] e;
        @(negedge clk); addr = a; addr_valid = 1;
        @(negedge clk); addr_valid = 0;
        e = exp_code(a[23:16], m0, m1);
        check(req, {region_flags, region_code}, {3'b001 << e, e});
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 code", region_code, 2'b00);
        check("R1 flags", region_flags, 3'b000);
        rd_check(0, "R1 limit0");
        rd_check(1, "R1 limit1");
        classify(24'hFFFFFF, "R4 both zero, top page low");
        classify(24'h000000, "R5 reset low");
        // worked example
        wr(0, 8'h01); wr(1, 8'h40);
        rd_check(0, "R3 limit0"); rd_check(1, "R3 limit1");
        classify(24'h00FFFF, "R5 low edge");
        classify(24'h010000, "R5 mid at limit0");
        classify(24'h3FFFFF, "R5 mid below limit1");
        classify(24'h400000, "R5 high at limit1");
        classify(24'hFFFFFF, "R6 high top");
        // R8 hold: change addr without valid
        @(negedge clk); addr = 24'h000000;
        @(negedge clk); check("R8 hold", region_code, 2'b10);
        // R2 write isolation
        wr(1, 8'h80);
        rd_check(0, "R2 limit0 kept");
        rd_check(1, "R2 limit1 written");
        // limit1 = 00H -> high empty
        wr(1, 8'h00);
        classify(24'hFF0000, "R4 limit1 zero page FF mid");
        classify(24'h00FFFF, "R5 low with limit1 zero");
        // limit0 = 00H, limit1 nonzero
        wr(0, 8'h00); wr(1, 8'h20);
        classify(24'hFFFFFF, "R4 limit0 zero all low");
        // equal limits
        wr(0, 8'h30); wr(1, 8'h30);
        classify(24'h2FFFFF, "R9 equal below");
        classify(24'h300000, "R9 equal at -> high");
        // inverted
        wr(0, 8'h50); wr(1, 8'h10);
        classify(24'h100000, "R9 inverted low precedence");
        classify(24'h500000, "R9 inverted high");
        classify(24'h4FFFFF, "R9 inverted below limit0");
        // random
        for (int i = 0; i < 300; i++) begin
            if (i % 10 == 0) begin
                wr(0, 8'($urandom)); wr(1, 8'($urandom));
                rd_check(i[4], "R3 random read");
            end
            classify(24'($urandom), "R5 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule